// File: doc/BRIEF.md
# Single-Slot Framed PCM Serial Port

This block is one side of a synchronous PCM serial link. It runs from the link's own data clock and follows a frame sync that arrives once per 8 kHz frame. From that sync it counts bit positions and picks out one 8-bit time slot, chosen by a 5-bit slot index. During that slot it does two things. It shifts the incoming line into a byte and reports the byte with a one-period valid strobe. It also shifts an outgoing byte onto the line, most significant bit first.

The receive side and the transmit side use opposite clock edges. Capture happens on the falling edge. Drive changes happen on the rising edge, so the far end sees stable data at its sampling point. Outside the slot the transmit line floats. An idle input holds the transmit line in high impedance at any time, and the receive side keeps working while idle is set. After 256 bit positions with no new sync, the port goes quiet and waits for the next sync.

Top module: `pcm_slot_port`

## Requirements
- R1: During and after reset, `rx_valid` is 0, `rx_byte` is 0 and `pcm_tx_oe` is 0. No slot is served until a frame sync has been seen.
- R2: `fsync` is sampled high on a falling edge. The next clock period is bit position 0. A new sync at any point restarts the count at 0 and discards any partial capture.
- R3: For `slot_idx` = n (0..31), the slot is bit positions 8n through 8n+7. Capture, strobe and drive happen only in those positions.
- R4: Inside the slot, `din` is sampled on the falling edge. The first slot bit lands in `rx_byte[7]` and the last in `rx_byte[0]`. Line values outside the slot do not affect `rx_byte`.
- R5: `rx_valid` is high for exactly one clock period. It starts at the falling edge that samples the eighth slot bit, and at that edge `rx_byte` takes the captured byte.
- R6: The transmit bit changes on the rising edge. Slot bit k carries `tx_byte[7-k]`. `tx_byte` is taken once, at the rising edge that starts the slot, and later changes do not affect the bits sent.
- R7: `pcm_tx_oe` is 0 outside the slot. It falls on the rising edge after the last slot bit. While it is 0, `pcm_tx` is high impedance.
- R8: `idle` high turns the output enable off at once. A slot that starts with idle high stays off. If idle is raised partway through a slot, the output stays off for the rest of that slot, even if idle drops again.
- R9: After bit position 255, if no new sync arrives, the port captures nothing, strobes nothing and drives nothing until the next sync.
- R10: `idle` has no effect on capture or on the `rx_valid` strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | PCM data clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fsync | input | 1 | Frame sync, one clock period wide |
| slot_idx | input | 5 | Index of the served 8-bit slot |
| idle | input | 1 | Forces the transmit line to high impedance |
| din | input | 1 | Serial receive line |
| tx_byte | input | 8 | Byte to send in the slot |
| pcm_tx | output | 1 | Serial transmit line, high impedance when not enabled |
| pcm_tx_oe | output | 1 | Transmit line enable |
| rx_byte | output | 8 | Last byte captured |
| rx_valid | output | 1 | One-period strobe for a new byte |

## Verification
The embedded assertions check the timing skeleton on every edge. After each sync the count restarts at 0 and then advances by one. The strobe never lasts two periods and appears only after a slot bit. The output enable turns on only at slot bit 0 and, while on, follows consecutive bit positions. Only the directed scenarios can show the data itself. They check the byte values in both directions and MSB-first order, where the slot sits for low, middle and top indices, idle asserted for a whole slot and for part of one, a sync that arrives mid-slot, and the stop after a frame with no new sync.

// File: rtl/pcm_pkg.sv
package pcm_pkg;
    // default geometry of the PCM frame
    localparam int SAMPLE_W_DEF = 8;   // bits per slot
    localparam int IDX_W_DEF    = 5;   // slot index width

    function automatic int lane_bits(input int sample_w);
        return (sample_w <= 1) ? 1 : $clog2(sample_w);
    endfunction
endpackage

// File: rtl/pcm_bit_timer.sv
module pcm_bit_timer
    import pcm_pkg::*;
#(
    parameter int SAMPLE_W = SAMPLE_W_DEF,
    parameter int IDX_W    = IDX_W_DEF,
    localparam int LANE_W  = lane_bits(SAMPLE_W),
    localparam int CNT_W   = IDX_W + LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fsync,
    input  logic [IDX_W-1:0]  slot_idx,
    output logic              slot_hit,
    output logic [LANE_W-1:0] lane_bit
);
    typedef struct packed {
        logic             active;
        logic [CNT_W-1:0] pos;
    } tmr_t;

    localparam logic [CNT_W-1:0] LAST_POS = {CNT_W{1'b1}};

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (fsync) begin
            tmr_d.active = 1'b1;
            tmr_d.pos    = '0;
        end else if (tmr_q.active) begin
            if (tmr_q.pos == LAST_POS) begin
                tmr_d.active = 1'b0;
            end else begin
                tmr_d.pos = tmr_q.pos + 1'b1;
            end
        end
    end

    // the count advances on the capture edge
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign slot_hit = tmr_q.active && (tmr_q.pos[CNT_W-1:LANE_W] == slot_idx);
    assign lane_bit = tmr_q.pos[LANE_W-1:0];

    // R2
    sync_restart_chk: assert property (@(negedge clk) disable iff (!rst_n)
        $past(fsync) |-> (tmr_q.active && tmr_q.pos == '0));

    // R2
    pos_step_chk: assert property (@(negedge clk) disable iff (!rst_n)
        (tmr_q.active && $past(tmr_q.active) && !$past(fsync))
            |-> tmr_q.pos == CNT_W'($past(tmr_q.pos) + 1'b1));
endmodule

// File: rtl/pcm_rx_capture.sv
module pcm_rx_capture
    import pcm_pkg::*;
#(
    parameter int SAMPLE_W = SAMPLE_W_DEF,
    localparam int LANE_W  = lane_bits(SAMPLE_W)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                fsync,
    input  logic                slot_hit,
    input  logic [LANE_W-1:0]   lane_bit,
    input  logic                din,
    output logic [SAMPLE_W-1:0] rx_byte,
    output logic                rx_valid
);
    typedef struct packed {
        logic [SAMPLE_W-1:0] shreg;
        logic [SAMPLE_W-1:0] word;
        logic                valid;
    } rx_t;

    localparam logic [LANE_W-1:0] LAST_LANE = LANE_W'(SAMPLE_W - 1);

    rx_t rx_d, rx_q;

    always_comb begin
        rx_d       = rx_q;
        rx_d.valid = 1'b0;
        if (fsync) begin
            rx_d.shreg = '0;
        end else if (slot_hit) begin
            rx_d.shreg = {rx_q.shreg[SAMPLE_W-2:0], din};
            if (lane_bit == LAST_LANE) begin
                rx_d.word  = {rx_q.shreg[SAMPLE_W-2:0], din};
                rx_d.valid = 1'b1;
            end
        end
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q <= '0;
        end else begin
            rx_q <= rx_d;
        end
    end

    assign rx_byte  = rx_q.word;
    assign rx_valid = rx_q.valid;

    // R5
    strobe_single_chk: assert property (@(negedge clk) disable iff (!rst_n)
        rx_q.valid |=> !rx_q.valid);

    // R3
    strobe_in_slot_chk: assert property (@(negedge clk) disable iff (!rst_n)
        rx_q.valid |-> $past(slot_hit));
endmodule

// File: rtl/pcm_tx_drive.sv
module pcm_tx_drive
    import pcm_pkg::*;
#(
    parameter int SAMPLE_W = SAMPLE_W_DEF,
    localparam int LANE_W  = lane_bits(SAMPLE_W)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                slot_hit,
    input  logic [LANE_W-1:0]   lane_bit,
    input  logic                idle,
    input  logic [SAMPLE_W-1:0] tx_byte,
    output logic                tx_bit,
    output logic                tx_oe
);
    typedef struct packed {
        logic [SAMPLE_W-1:0] shreg;
        logic [LANE_W-1:0]   lane;
        logic                bit_out;
        logic                oe;
    } tx_t;

    tx_t tx_d, tx_q;

    always_comb begin
        tx_d      = tx_q;
        tx_d.lane = lane_bit;
        if (!slot_hit) begin
            tx_d.oe      = 1'b0;
            tx_d.bit_out = 1'b0;
        end else if (lane_bit == '0) begin
            // slot start: take the byte once
            tx_d.oe      = !idle;
            tx_d.bit_out = tx_byte[SAMPLE_W-1];
            tx_d.shreg   = tx_byte << 1;
        end else begin
            // an idle seen inside the slot keeps it off to the end
            tx_d.oe      = tx_q.oe && !idle;
            tx_d.bit_out = tx_q.shreg[SAMPLE_W-1];
            tx_d.shreg   = tx_q.shreg << 1;
        end
    end

    // drive changes on the launch edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q <= '0;
        end else begin
            tx_q <= tx_d;
        end
    end

    assign tx_bit = tx_q.bit_out;
    assign tx_oe  = tx_q.oe && !idle;

    // R7
    oe_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_q.oe) |-> tx_q.lane == '0);

    // R7
    oe_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_q.oe && $past(tx_q.oe)) |-> tx_q.lane == LANE_W'($past(tx_q.lane) + 1'b1));

    // R8
    oe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_q.oe |-> !$past(idle));
endmodule

// File: rtl/pcm_slot_port.sv
module pcm_slot_port
    import pcm_pkg::*;
#(
    parameter int SAMPLE_W = SAMPLE_W_DEF,
    parameter int IDX_W    = IDX_W_DEF,
    localparam int LANE_W  = lane_bits(SAMPLE_W)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                fsync,
    input  logic [IDX_W-1:0]    slot_idx,
    input  logic                idle,
    input  logic                din,
    input  logic [SAMPLE_W-1:0] tx_byte,
    output logic                pcm_tx,
    output logic                pcm_tx_oe,
    output logic [SAMPLE_W-1:0] rx_byte,
    output logic                rx_valid
);
    logic              slot_hit;
    logic [LANE_W-1:0] lane_bit;
    logic              tx_bit;
    logic              tx_oe;

    pcm_bit_timer #(.SAMPLE_W(SAMPLE_W), .IDX_W(IDX_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .fsync    (fsync),
        .slot_idx (slot_idx),
        .slot_hit (slot_hit),
        .lane_bit (lane_bit)
    );

    pcm_rx_capture #(.SAMPLE_W(SAMPLE_W)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .fsync    (fsync),
        .slot_hit (slot_hit),
        .lane_bit (lane_bit),
        .din      (din),
        .rx_byte  (rx_byte),
        .rx_valid (rx_valid)
    );

    pcm_tx_drive #(.SAMPLE_W(SAMPLE_W)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .slot_hit (slot_hit),
        .lane_bit (lane_bit),
        .idle     (idle),
        .tx_byte  (tx_byte),
        .tx_bit   (tx_bit),
        .tx_oe    (tx_oe)
    );

    assign pcm_tx_oe = tx_oe;
    assign pcm_tx    = tx_oe ? tx_bit : 1'bz;
endmodule

// File: tb/pcm_slot_port_tb.sv
module pcm_slot_port_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fsync = 1'b0;
    logic [4:0] slot_idx = '0;
    logic       idle = 1'b0;
    logic       din = 1'b0;
    logic [7:0] tx_byte = '0;
    wire        pcm_tx;
    logic       pcm_tx_oe;
    logic [7:0] rx_byte;
    logic       rx_valid;

    int  total = 0;
    int  bad   = 0;
    bit  done  = 0;

    always #2 clk = ~clk;   // 250 MHz

    pcm_slot_port u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .fsync     (fsync),
        .slot_idx  (slot_idx),
        .idle      (idle),
        .din       (din),
        .tx_byte   (tx_byte),
        .pcm_tx    (pcm_tx),
        .pcm_tx_oe (pcm_tx_oe),
        .rx_byte   (rx_byte),
        .rx_valid  (rx_valid)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s at %0t: actual=%0h expected=%0h", req, $time, act, exp);
        end
    endtask

    function automatic bit idle_at(input int mode, input int pos, input int p0);
        if (mode == 1) return 1'b1;
        if (mode == 2) return (pos == p0 + 3) || (pos == p0 + 4);
        return 1'b0;
    endfunction

    // cycle k drives line bit of position k-1 and controls for position k
    task automatic run_frame(input int slot, input logic [7:0] txb, input logic [7:0] rxb,
                             input int mode, input int npos, input string tag);
        bit reg_oe = 1'b0;
        int p0 = slot * 8;
        for (int k = 0; k <= npos; k++) begin
            int p = k - 1;
            bit in_s = (p >= 0) && (p < 256) && (p / 8 == slot);
            int b = (p >= 0) ? (p % 8) : 0;
            bit vis;
            @(posedge clk); #1;
            fsync    = (k == 0);
            slot_idx = 5'(slot);
            din      = in_s ? rxb[7 - b] : ^(p & 5);
            idle     = idle_at(mode, k, p0);
            tx_byte  = (k == p0) ? txb : ~txb;
            @(negedge clk); #1;
            if (k == 0) begin
                check({tag, " R2 no strobe on sync"}, {31'd0, rx_valid}, 32'd0);
            end else begin
                if (!in_s)       reg_oe = 1'b0;
                else if (b == 0) reg_oe = !idle_at(mode, p, p0);
                else             reg_oe = reg_oe && !idle_at(mode, p, p0);
                vis = reg_oe && !idle_at(mode, k, p0);
                check({tag, " R7 R8 enable"}, {31'd0, pcm_tx_oe}, {31'd0, vis});
                if (vis) check({tag, " R6 tx bit"}, {31'd0, pcm_tx}, {31'd0, txb[7 - b]});
                if (in_s && b == 7) begin
                    check({tag, " R5 strobe"}, {31'd0, rx_valid}, 32'd1);
                    check({tag, " R4 rx byte"}, {24'd0, rx_byte}, {24'd0, rxb});
                end else begin
                    check({tag, " R3 R5 no strobe"}, {31'd0, rx_valid}, 32'd0);
                end
            end
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        check("R1 valid in reset", {31'd0, rx_valid}, 32'd0);
        check("R1 enable in reset", {31'd0, pcm_tx_oe}, 32'd0);
        rst_n = 1'b1;
        for (int i = 0; i < 12; i++) begin
            @(posedge clk); #1;
            din = i[0];
            @(negedge clk); #1;
            check("R1 enable before sync", {31'd0, pcm_tx_oe}, 32'd0);
            check("R1 valid before sync", {31'd0, rx_valid}, 32'd0);
        end
        check("R1 rx byte after reset", {24'd0, rx_byte}, 32'd0);
    endtask

    task automatic t_basic();
        run_frame(0, 8'hA5, 8'h3C, 0, 12, "R3 slot0");
        run_frame(5, 8'h81, 8'h7E, 0, 48, "R3 slot5");
        run_frame(31, 8'h96, 8'hC3, 0, 256, "R3 slot31");
    endtask

    task automatic t_idle_whole();
        run_frame(2, 8'hFF, 8'h5A, 1, 26, "R10 idle");
    endtask

    task automatic t_idle_mid();
        run_frame(3, 8'hF0, 8'h0F, 2, 34, "R8 idle mid");
    endtask

    task automatic t_restart();
        run_frame(1, 8'h33, 8'hE1, 0, 12, "R2 cut");
        run_frame(1, 8'h6C, 8'h29, 0, 20, "R2 after");
    endtask

    task automatic t_frame_end();
        run_frame(0, 8'h5B, 8'hB4, 0, 270, "R9 end");
    endtask

    initial begin
        t_reset();
        t_basic();
        t_idle_whole();
        t_idle_mid();
        t_restart();
        t_frame_end();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog R1: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule